// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of an external flash device. Once the host has launched a program or erase operation, it pulses a start request. The request carries the operation kind, the word address to watch, the expected value of status bit 7 for a program, a detection mode and a poll limit. The block then issues single-word reads on a request/acknowledge read port, one at a time. It decides from the encoded status bits in each returned word whether the device has finished.

Two detection methods are provided.

- **Data polling** checks bit 7 of each read. After a program, bit 7 matches the expected value once the operation is done. After an erase, bit 7 reads 1 once the operation is done.
- **Toggle detection** compares bit 6 of each read with bit 6 of the read before it. When the bit stops changing, the block issues one further read and returns that word as the verified data.

An optional ready/busy level can also end polling. If no completion is seen within the programmed number of status reads, the block reports an error. Both outcomes are single-cycle pulses.

Top module: `flash_done_poller`

## Requirements
- R1: A start request is taken only while the block is idle. A start request while busy changes neither the read address nor the operation in progress.
- R2: The first read request is raised in the cycle after the start is accepted. Every read uses the captured address. A request stays high, with a stable address, until it is acknowledged. No request is raised while idle.
- R3: Data-polling after a program: an acknowledged read completes the operation when read bit 7 equals the expected bit. The word is then returned on `data_o`. A read whose bit 7 is the complement keeps polling.
- R4: Data-polling after an erase: a read with bit 7 = 0 keeps polling, and a read with bit 7 = 1 completes the operation.
- R5: Toggle mode (`toggle_i` = 1): the first status read never completes by itself. Each later read completes the operation when its bit 6 equals bit 6 of the previous read, and keeps polling when it differs. After completion, one verify read is issued, and its word is returned on `data_o` with the done pulse.
- R6: With `rb_en_i` = 1, a status read acknowledged while `rb_i` is high counts as completion. In toggle mode the verify read still follows. With `rb_en_i` = 0, `rb_i` has no effect.
- R7: With limit L (0 treated as 1), if the L-th status read is acknowledged without completion, `err_o` pulses and the block returns to idle without a done pulse.
- R8: `done_o` and `err_o` are one-cycle pulses, never high together. Each rises in the cycle after the acknowledge that ends the operation, and `busy_o` is already low in that cycle.
- R9: After reset, `busy_o`, `rd_req_o`, `done_o` and `err_o` are low and `data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| erase_i | input | 1 | 1 = erase operation, 0 = program |
| toggle_i | input | 1 | 1 = toggle detection, 0 = data polling |
| rb_en_i | input | 1 | Allow ready/busy level to end polling |
| addr_i | input | ADDR_W | Word address to poll |
| exp_bit_i | input | 1 | Expected bit 7 of the programmed word |
| limit_i | input | CNT_W | Maximum number of status reads |
| rb_i | input | 1 | Ready/busy level, low = busy |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid in same cycle |
| rd_data_i | input | DATA_W | Read data |
| busy_o | output | 1 | Operation being polled |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Poll-limit error pulse |
| data_o | output | DATA_W | Final read word, held until the next completion |

## Verification
The first read request is due one clock edge after the start is sampled. The done or error pulse is due one edge after the acknowledge that ends the operation. The pulse then falls one edge later, and `busy_o` is already low when it rises. The bench drives stimulus and samples results on the falling clock edge. At the first falling edge after the start, it looks for the request. It acknowledges each request for exactly one cycle. It expects the result at the falling edge after the final acknowledge and nowhere earlier. It also counts how many reads each operation used, so that one read too many or too few is reported.

// File: rtl/fpoll_pkg.sv
`timescale 1ns/1ps
package fpoll_pkg;
  localparam int unsigned DP_BIT = 7;  // data-polling status bit
  localparam int unsigned TG_BIT = 6;  // toggle status bit

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POLL = 2'd1,
    ST_VRFY = 2'd2
  } poll_st_e;
endpackage

// File: rtl/fpoll_status_eval.sv
`timescale 1ns/1ps
module fpoll_status_eval (
  input  logic toggle_i,
  input  logic erase_i,
  input  logic exp_bit_i,
  input  logic rb_en_i,
  input  logic rb_i,
  input  logic prev_vld_i,
  input  logic prev_b6_i,
  input  logic b7_i,
  input  logic b6_i,
  output logic complete_o
);
  logic dp_ok, tg_ok, rb_ok;

  always_comb begin
    dp_ok      = erase_i ? b7_i : (b7_i == exp_bit_i);
    tg_ok      = prev_vld_i && (b6_i == prev_b6_i);
    rb_ok      = rb_en_i && rb_i;
    complete_o = rb_ok || (toggle_i ? tg_ok : dp_ok);
  end
endmodule

// File: rtl/fpoll_limit_cnt.sv
`timescale 1ns/1ps
module fpoll_limit_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             at_limit_o
);
  localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && (cnt_q != '1))   cnt_q <= cnt_q + 1'b1;
  end

  // true when the read now being acknowledged is the last one allowed
  assign at_limit_o = ({1'b0, cnt_q} + ONE) >= {1'b0, limit_i};
endmodule

// File: rtl/fpoll_seq.sv
`timescale 1ns/1ps
module fpoll_seq
  import fpoll_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     ack_i,
  input  logic     toggle_i,
  input  logic     complete_i,
  input  logic     at_limit_i,
  output poll_st_e st_o,
  output logic     req_o,
  output logic     accept_o,
  output logic     poll_ack_o,
  output logic     fin_ack_o,
  output logic     done_o,
  output logic     err_o
);
  poll_st_e st_q, st_d;
  logic     done_d, err_d, done_q, err_q;

  always_comb begin
    st_d       = st_q;
    accept_o   = 1'b0;
    poll_ack_o = 1'b0;
    fin_ack_o  = 1'b0;
    done_d     = 1'b0;
    err_d      = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d     = ST_POLL;
        accept_o = 1'b1;
      end
      ST_POLL: if (ack_i) begin
        poll_ack_o = 1'b1;
        if (complete_i) begin
          if (toggle_i) st_d = ST_VRFY;
          else begin
            st_d      = ST_IDLE;
            done_d    = 1'b1;
            fin_ack_o = 1'b1;
          end
        end else if (at_limit_i) begin
          st_d  = ST_IDLE;
          err_d = 1'b1;
        end
      end
      ST_VRFY: if (ack_i) begin
        st_d      = ST_IDLE;
        done_d    = 1'b1;
        fin_ack_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign st_o   = st_q;
  assign req_o  = (st_q == ST_POLL) || (st_q == ST_VRFY);
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/flash_done_poller.sv
`timescale 1ns/1ps
module flash_done_poller
  import fpoll_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic              toggle_i,
  input  logic              rb_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              exp_bit_i,
  input  logic [CNT_W-1:0]  limit_i,
  input  logic              rb_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] data_o
);
  poll_st_e          st;
  logic              accept, poll_ack, fin_ack, complete, at_limit;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  limit_q;
  logic [DATA_W-1:0] data_q;
  logic              erase_q, toggle_q, rb_en_q, exp_q;
  logic              prev_vld_q, prev_b6_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      limit_q  <= '0;
      erase_q  <= 1'b0;
      toggle_q <= 1'b0;
      rb_en_q  <= 1'b0;
      exp_q    <= 1'b0;
    end else if (accept) begin
      addr_q   <= addr_i;
      limit_q  <= limit_i;
      erase_q  <= erase_i;
      toggle_q <= toggle_i;
      rb_en_q  <= rb_en_i;
      exp_q    <= exp_bit_i;
    end
  end

  // bit 6 history for toggle detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_vld_q <= 1'b0;
      prev_b6_q  <= 1'b0;
    end else if (accept) begin
      prev_vld_q <= 1'b0;
    end else if (poll_ack) begin
      prev_vld_q <= 1'b1;
      prev_b6_q  <= rd_data_i[TG_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (fin_ack) data_q <= rd_data_i;
  end

  fpoll_status_eval u_eval (
    .toggle_i   (toggle_q),
    .erase_i    (erase_q),
    .exp_bit_i  (exp_q),
    .rb_en_i    (rb_en_q),
    .rb_i       (rb_i),
    .prev_vld_i (prev_vld_q),
    .prev_b6_i  (prev_b6_q),
    .b7_i       (rd_data_i[DP_BIT]),
    .b6_i       (rd_data_i[TG_BIT]),
    .complete_o (complete)
  );

  fpoll_limit_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .inc_i      (poll_ack),
    .limit_i    (limit_q),
    .at_limit_o (at_limit)
  );

  fpoll_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ack_i      (rd_ack_i),
    .toggle_i   (toggle_q),
    .complete_i (complete),
    .at_limit_i (at_limit),
    .st_o       (st),
    .req_o      (rd_req_o),
    .accept_o   (accept),
    .poll_ack_o (poll_ack),
    .fin_ack_o  (fin_ack),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  assign rd_addr_o = addr_q;
  assign busy_o    = (st != ST_IDLE);
  assign data_o    = data_q;
endmodule

// File: rtl/flash_done_poller_chk.sv
`timescale 1ns/1ps
module flash_done_poller_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              rd_req_o,
  input logic              rd_ack_i,
  input logic [ADDR_W-1:0] rd_addr_o
);
  AST_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(rd_addr_o)); // R1
  AST_FIRST_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> rd_req_o); // R2
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)); // R2
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_req_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R8
  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R8
  AST_END_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> $past(rd_ack_i) && !busy_o); // R8
endmodule

bind flash_done_poller flash_done_poller_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .rd_req_o  (rd_req_o),
  .rd_ack_i  (rd_ack_i),
  .rd_addr_o (rd_addr_o)
);

// File: tb/flash_done_poller_tb_top.sv
`timescale 1ns/1ps
module flash_done_poller_tb_top;
  typedef struct packed {
    logic        tog;
    logic        ers;
    logic        rben;
    logic        expb;
    logic [7:0]  lim;
    logic [15:0] r0;
    logic [15:0] r1;
    logic [15:0] r2;
    logic [15:0] r3;
    logic [3:0]  rbm;   // rb_i level for read n at bit n
    logic        xerr;
    logic [3:0]  xrd;   // expected number of reads
    logic [15:0] xdat;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0,1'b0,1'b0,1'b1,8'd8, 16'h0025,16'h00A5,16'h0000,16'h0000,4'b0000,1'b0,4'd2,16'h00A5},
    '{1'b0,1'b0,1'b0,1'b0,8'd8, 16'h0092,16'h0092,16'h0012,16'h0000,4'b0000,1'b0,4'd3,16'h0012},
    '{1'b0,1'b1,1'b0,1'b0,8'd8, 16'h0000,16'hFF7F,16'hFFFF,16'h0000,4'b0000,1'b0,4'd3,16'hFFFF},
    '{1'b1,1'b0,1'b0,1'b0,8'd8, 16'h0040,16'h0000,16'h0000,16'h1234,4'b0000,1'b0,4'd4,16'h1234},
    '{1'b1,1'b0,1'b0,1'b0,8'd8, 16'h0040,16'h0040,16'hBEEF,16'h0000,4'b0000,1'b0,4'd3,16'hBEEF},
    '{1'b0,1'b0,1'b0,1'b1,8'd3, 16'h0000,16'h0000,16'h0000,16'h0000,4'b0000,1'b1,4'd3,16'h0000},
    '{1'b0,1'b0,1'b1,1'b1,8'd8, 16'h0000,16'h0000,16'h0000,16'h0000,4'b0010,1'b0,4'd2,16'h0000},
    '{1'b0,1'b0,1'b0,1'b1,8'd2, 16'h0000,16'h0000,16'h0000,16'h0000,4'b1111,1'b1,4'd2,16'h0000},
    '{1'b1,1'b0,1'b1,1'b0,8'd8, 16'h0040,16'h0000,16'h5555,16'h0000,4'b0010,1'b0,4'd3,16'h5555},
    '{1'b1,1'b1,1'b0,1'b0,8'd2, 16'h0040,16'h0000,16'h0040,16'h0000,4'b0000,1'b1,4'd2,16'h0000}
  };

  function automatic string vtag(input int i);
    case (i)
      0, 1:    return "R3";
      2:       return "R4";
      3, 4:    return "R5";
      5, 9:    return "R7";
      default: return "R6";
    endcase
  endfunction

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        start_i = 1'b0, erase_i = 1'b0, toggle_i = 1'b0, rb_en_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic        exp_bit_i = 1'b0;
  logic [15:0] limit_i = '0;
  logic        rb_i = 1'b0;
  logic        rd_req_o;
  logic [19:0] rd_addr_o;
  logic        rd_ack_i = 1'b0;
  logic [15:0] rd_data_i = '0;
  logic        busy_o, done_o, err_o;
  logic [15:0] data_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  flash_done_poller dut_i (
    .clk_i, .rst_ni, .start_i, .erase_i, .toggle_i, .rb_en_i, .addr_i,
    .exp_bit_i, .limit_i, .rb_i, .rd_req_o, .rd_addr_o, .rd_ack_i,
    .rd_data_i, .busy_o, .done_o, .err_o, .data_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input logic [19:0] a, input string tag, input bit poke);
    int nrd = 0;
    bit fin = 1'b0;
    logic [15:0] rsp;
    @(negedge clk_i);
    start_i = 1'b1; erase_i = v.ers; toggle_i = v.tog; rb_en_i = v.rben;
    exp_bit_i = v.expb; limit_i = {8'h00, v.lim}; addr_i = a; rb_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk({tag, " R2 first request"}, {30'd0, rd_req_o, busy_o}, 32'd3);
    for (int c = 0; c < 64 && !fin; c++) begin
      if (done_o || err_o) fin = 1'b1;
      else begin
        if (rd_req_o) begin
          chk({tag, " R2 read address"}, {12'd0, rd_addr_o}, {12'd0, a});
          case (nrd)
            0:       rsp = v.r0;
            1:       rsp = v.r1;
            2:       rsp = v.r2;
            default: rsp = v.r3;
          endcase
          rd_ack_i = 1'b1; rd_data_i = rsp;
          rb_i = v.rbm[(nrd > 3) ? 3 : nrd];
          nrd++;
        end
        if (poke) begin  // R1: start while busy with different settings
          start_i = 1'b1; addr_i = a ^ 20'hFFFFF;
          erase_i = ~v.ers; toggle_i = ~v.tog; exp_bit_i = ~v.expb;
        end
        @(negedge clk_i);
        rd_ack_i = 1'b0; start_i = 1'b0;
      end
    end
    chk({tag, " outcome done/err"}, {30'd0, done_o, err_o}, v.xerr ? 32'd1 : 32'd2);
    chk({tag, " read count"}, nrd, {28'd0, v.xrd});
    chk({tag, " R8 busy low at pulse"}, {31'd0, busy_o}, 32'd0);
    if (!v.xerr) chk({tag, " result word"}, {16'd0, data_o}, {16'd0, v.xdat});
    @(negedge clk_i);
    chk({tag, " R8 single-cycle pulse"}, {30'd0, done_o, err_o}, 32'd0);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9 reset outputs", {28'd0, busy_o, rd_req_o, done_o, err_o}, 32'd0);
    chk("R9 reset data", {16'd0, data_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R9 idle after release", {29'd0, busy_o, rd_req_o, done_o}, 32'd0);

    for (int i = 0; i < NVEC; i++)
      run_vec(VEC[i], 20'h01000 + 20'(i * 16), vtag(i), 1'b0);

    // R1: start pulses during polling are ignored
    run_vec(VEC[0], 20'h0ABC0, "R1", 1'b1);
    run_vec(VEC[3], 20'h03210, "R1", 1'b1);

    // R7: limit zero behaves as one
    run_vec('{1'b0,1'b0,1'b0,1'b1,8'd0, 16'h0,16'h0,16'h0,16'h0,4'b0,1'b1,4'd1,16'h0},
            20'h00777, "R7 zero limit", 1'b0);

    // R3: completing on the last allowed read gives done, not error
    run_vec('{1'b0,1'b0,1'b0,1'b1,8'd2, 16'h0000,16'h0080,16'h0,16'h0,4'b0,1'b0,4'd2,16'h0080},
            20'h00555, "R3 boundary", 1'b0);

    // R2: no request while idle
    repeat (3) @(negedge clk_i);
    chk("R2 idle no request", {31'd0, rd_req_o}, 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule